// File: doc/BRIEF.md
# SDRAM Bank State Legality Checker

This block watches the command bus of a four-bank single-data-rate SDRAM and keeps a per-bank model of where each bank stands. The model covers idle, opening, open, bursting and closing, plus the device-wide phases of refresh, mode-register load and close-all. Each command that is not allowed for the addressed bank, or for the device as a whole at that moment, raises a one-cycle flag with a reason code. The command that raised the flag leaves the model untouched.

It sits beside a memory controller as a protocol monitor, or in front of a memory model as a guard. All timing limits are given as whole clock cycles through parameters, and the burst length is a live input. Data, DQ timing and self refresh are not modelled.

Top module: `sdram_bank_guard`

## Requirements
- R1: After reset every bank reads Idle (code 0), `all_idle_o` is 1 and `illegal_o` is 0.
- R2: An ACTIVATE (code 2) to an Idle bank puts it in Opening (code 1). The bank becomes Open (code 2) so that a command issued T_RCD cycles after the ACTIVATE is the first one it accepts.
- R3: A PRECHARGE (code 7) to an Open, Reading or Writing bank puts it in Closing (code 5), and the bank is Idle again T_RP cycles later. A PRECHARGE to an Idle bank is legal and changes nothing.
- R4: READ (code 3) and WRITE (code 5) to an open bank show Reading (code 3) or Writing (code 4) for the burst, then Open. The burst lasts 1, 2, 4 or 8 cycles for `burst_len_i` values 0 to 3, so a one-cycle burst leaves the bank Open at once.
- R5: READ with auto close (code 4) and WRITE with auto close (code 6) show codes 6 and 7 for the burst length plus T_RP cycles, after which the bank is Idle.
- R6: Any command other than NOP or INHIBIT to a bank in code 1, 5, 6 or 7 is illegal with reason 1 (bank busy). An ACTIVATE to a bank that is not Idle also gives reason 1. Other banks keep accepting commands that fit their own state.
- R7: READ or WRITE of either kind to an Idle bank is illegal with reason 2 (bank not open).
- R8: REFRESH (code 9) and MODE LOAD (code 10) are legal only while every bank is Idle and no device-wide phase runs. Otherwise they are illegal with reason 3.
- R9: After REFRESH, MODE LOAD or CLOSE ALL, every command other than NOP (0) or INHIBIT (1) is illegal with reason 4 until T_RC, T_MRD or T_RP cycles have passed. `all_idle_o` stays 0 during that time.
- R10: CLOSE ALL (code 8) sets every bank to Idle at once. It is illegal with reason 1 if any bank is in code 1, 5, 6 or 7.
- R11: STOP (code 11) ends the most recent plain READ or WRITE burst, in whichever bank it runs, returning that bank to Open. The addressed bank is not changed.
- R12: A new READ or WRITE to a bank that is still Reading or Writing restarts the burst with the new length.
- R13: Commands are evaluated and timers advance only when `cke_i` was high in the previous cycle and is high in the current one. Otherwise states hold and no flag is raised.
- R14: `illegal_o` and `reason_o` appear in the cycle after the command and last one cycle. The reason is 0 when no flag is raised. Codes 12 to 15 are illegal with reason 5 (unknown). NOP and INHIBIT are never illegal, and an illegal command changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable seen by the memory |
| cmd_i | input | 4 | Decoded command code |
| bank_i | input | 2 | Addressed bank |
| burst_len_i | input | 2 | Burst length select, 2^value cycles |
| bank_state_o | output | 12 | State of bank b in bits 3b+2..3b |
| all_idle_o | output | 1 | Every bank Idle and no device-wide phase running |
| illegal_o | output | 1 | Previous command was illegal |
| reason_o | output | 3 | Why the previous command was illegal |

## Verification
The main stimulus is one long command stream in which banks pass through every state. Each command type is tried both where it is legal and where it is not, so a wrong reason code shows up as a different code, not just as a missing flag. Commands are placed exactly on the last blocked cycle and on the first free cycle of every timer. This separates a timer that is one cycle short or long from a correct one. Further streams drop CKE in the middle of an opening, run a full eight-cycle burst, and apply reset with banks open, which together separate frozen timers from running ones.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'd0,
    CMD_INHIBIT = 4'd1,
    CMD_ACT     = 4'd2,
    CMD_RD      = 4'd3,
    CMD_RDA     = 4'd4,
    CMD_WR      = 4'd5,
    CMD_WRA     = 4'd6,
    CMD_PRE     = 4'd7,
    CMD_PREALL  = 4'd8,
    CMD_REF     = 4'd9,
    CMD_LMR     = 4'd10,
    CMD_BST     = 4'd11
  } cmd_e;

  typedef enum logic [2:0] {
    BS_IDLE     = 3'd0,
    BS_OPENING  = 3'd1,
    BS_OPEN     = 3'd2,
    BS_READ     = 3'd3,
    BS_WRITE    = 3'd4,
    BS_CLOSING  = 3'd5,
    BS_READ_AC  = 3'd6,
    BS_WRITE_AC = 3'd7
  } bank_st_e;

  typedef enum logic [3:0] {
    BA_KEEP,
    BA_OPEN,
    BA_READ,
    BA_WRITE,
    BA_READ_AC,
    BA_WRITE_AC,
    BA_CLOSE,
    BA_STOP,
    BA_FORCE_IDLE
  } bank_act_e;

  typedef enum logic [1:0] {
    GO_NONE,
    GO_REFRESH,
    GO_MODE,
    GO_CLOSE_ALL
  } glob_op_e;

  typedef enum logic [2:0] {
    RSN_NONE         = 3'd0,
    RSN_BANK_BUSY    = 3'd1,
    RSN_NOT_OPEN     = 3'd2,
    RSN_NOT_ALL_IDLE = 3'd3,
    RSN_DEV_BUSY     = 3'd4,
    RSN_UNKNOWN      = 3'd5
  } reason_e;

  function automatic int unsigned max_int(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Burst duration in cycles for the two-bit length select.
  function automatic int unsigned burst_cycles(logic [1:0] code);
    return 32'd1 << code;
  endfunction

  // Stable state reached when a timed phase runs out.
  function automatic bank_st_e settle_state(bank_st_e s);
    case (s)
      BS_OPENING, BS_READ, BS_WRITE:         return BS_OPEN;
      BS_CLOSING, BS_READ_AC, BS_WRITE_AC:   return BS_IDLE;
      default:                               return s;
    endcase
  endfunction

  // Phases that must not be disturbed by a command to the same bank.
  function automatic logic is_transient(bank_st_e s);
    return (s == BS_OPENING) || (s == BS_CLOSING) ||
           (s == BS_READ_AC) || (s == BS_WRITE_AC);
  endfunction

  function automatic logic is_open(bank_st_e s);
    return (s == BS_OPEN) || (s == BS_READ) || (s == BS_WRITE);
  endfunction

endpackage

// File: rtl/sbg_bank.sv
module sbg_bank
  import sbg_pkg::*;
#(
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             track_i,
  input  bank_act_e        act_i,
  input  logic [CNT_W-1:0] burst_i,
  output bank_st_e         state_o
);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] hold_q, hold_d;

  // Timed phase requested by the action, and its total length in cycles.
  logic             load;
  bank_st_e         load_st;
  logic [CNT_W-1:0] load_len;

  always_comb begin
    load     = 1'b1;
    load_st  = st_q;
    load_len = '0;
    case (act_i)
      BA_OPEN: begin
        load_st  = BS_OPENING;
        load_len = CNT_W'(T_RCD);
      end
      BA_READ: begin
        load_st  = BS_READ;
        load_len = burst_i;
      end
      BA_WRITE: begin
        load_st  = BS_WRITE;
        load_len = burst_i;
      end
      BA_READ_AC: begin
        load_st  = BS_READ_AC;
        load_len = burst_i + CNT_W'(T_RP);
      end
      BA_WRITE_AC: begin
        load_st  = BS_WRITE_AC;
        load_len = burst_i + CNT_W'(T_RP);
      end
      BA_CLOSE: begin
        load_st  = BS_CLOSING;
        load_len = CNT_W'(T_RP);
      end
      default: load = 1'b0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    if (track_i) begin
      if (act_i == BA_STOP) begin
        st_d   = BS_OPEN;
        hold_d = '0;
      end else if (act_i == BA_FORCE_IDLE) begin
        st_d   = BS_IDLE;
        hold_d = '0;
      end else if (load) begin
        if (load_len <= CNT_W'(1)) begin
          st_d   = settle_state(load_st);
          hold_d = '0;
        end else begin
          st_d   = load_st;
          hold_d = load_len - CNT_W'(1);
        end
      end else if (hold_q != '0) begin
        hold_d = hold_q - CNT_W'(1);
        if (hold_q == CNT_W'(1)) begin
          st_d = settle_state(st_q);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= BS_IDLE;
      hold_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
    end
  end

  assign state_o = st_q;

endmodule

// File: rtl/sbg_global.sv
module sbg_global
  import sbg_pkg::*;
#(
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RC  = 6,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned BA_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cke_i,
  input  glob_op_e        op_i,
  input  logic            burst_start_i,
  input  logic [BA_W-1:0] burst_bank_i,
  output logic            track_o,
  output logic            busy_o,
  output logic [BA_W-1:0] last_bank_o,
  output logic            last_valid_o
);

  logic             cke_q;
  logic [CNT_W-1:0] gcnt_q;

  function automatic logic [CNT_W-1:0] op_len(glob_op_e op);
    case (op)
      GO_REFRESH:   return CNT_W'(T_RC);
      GO_MODE:      return CNT_W'(T_MRD);
      GO_CLOSE_ALL: return CNT_W'(T_RP);
      default:      return '0;
    endcase
  endfunction

  assign track_o = cke_q & cke_i;
  assign busy_o  = (gcnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_q        <= 1'b0;
      gcnt_q       <= '0;
      last_bank_o  <= '0;
      last_valid_o <= 1'b0;
    end else begin
      cke_q <= cke_i;
      if (track_o) begin
        if (op_i != GO_NONE) begin
          gcnt_q <= op_len(op_i) - CNT_W'(1);
        end else if (gcnt_q != '0) begin
          gcnt_q <= gcnt_q - CNT_W'(1);
        end
        if (burst_start_i) begin
          last_bank_o  <= burst_bank_i;
          last_valid_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sbg_decode.sv
module sbg_decode
  import sbg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BA_W      = 2
) (
  input  logic [3:0]                  cmd_i,
  input  logic [BA_W-1:0]             bank_i,
  input  bank_st_e [NUM_BANKS-1:0]    states_i,
  input  logic                        glob_busy_i,
  input  logic [BA_W-1:0]             last_bank_i,
  input  logic                        last_valid_i,
  output bank_act_e [NUM_BANKS-1:0]   act_o,
  output glob_op_e                    op_o,
  output logic                        burst_start_o,
  output reason_e                     reason_o
);

  logic     banks_idle;
  logic     any_transient;
  bank_st_e tgt;
  bank_st_e last_st;

  always_comb begin
    banks_idle    = 1'b1;
    any_transient = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (states_i[b] != BS_IDLE) banks_idle = 1'b0;
      if (is_transient(states_i[b])) any_transient = 1'b1;
    end
  end

  assign tgt     = states_i[bank_i];
  assign last_st = states_i[last_bank_i];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) act_o[b] = BA_KEEP;
    op_o          = GO_NONE;
    burst_start_o = 1'b0;
    reason_o      = RSN_NONE;
    if (cmd_i > CMD_BST) begin
      reason_o = RSN_UNKNOWN;
    end else if (cmd_i == CMD_NOP || cmd_i == CMD_INHIBIT) begin
      reason_o = RSN_NONE;
    end else if (glob_busy_i) begin
      reason_o = RSN_DEV_BUSY;
    end else begin
      case (cmd_i)
        CMD_ACT: begin
          if (tgt == BS_IDLE) act_o[bank_i] = BA_OPEN;
          else                reason_o      = RSN_BANK_BUSY;
        end
        CMD_RD, CMD_RDA, CMD_WR, CMD_WRA: begin
          if (is_transient(tgt)) begin
            reason_o = RSN_BANK_BUSY;
          end else if (tgt == BS_IDLE) begin
            reason_o = RSN_NOT_OPEN;
          end else begin
            burst_start_o = 1'b1;
            case (cmd_i)
              CMD_RD:  act_o[bank_i] = BA_READ;
              CMD_RDA: act_o[bank_i] = BA_READ_AC;
              CMD_WR:  act_o[bank_i] = BA_WRITE;
              default: act_o[bank_i] = BA_WRITE_AC;
            endcase
          end
        end
        CMD_PRE: begin
          if (is_transient(tgt))   reason_o      = RSN_BANK_BUSY;
          else if (is_open(tgt))   act_o[bank_i] = BA_CLOSE;
        end
        CMD_PREALL: begin
          if (any_transient) begin
            reason_o = RSN_BANK_BUSY;
          end else begin
            for (int b = 0; b < NUM_BANKS; b++) act_o[b] = BA_FORCE_IDLE;
            op_o = GO_CLOSE_ALL;
          end
        end
        CMD_REF, CMD_LMR: begin
          if (!banks_idle)            reason_o = RSN_NOT_ALL_IDLE;
          else if (cmd_i == CMD_REF)  op_o     = GO_REFRESH;
          else                        op_o     = GO_MODE;
        end
        default: begin
          // Stop: acts on the latest plain burst wherever it runs.
          if (last_valid_i && (last_st == BS_READ || last_st == BS_WRITE))
            act_o[last_bank_i] = BA_STOP;
        end
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_guard.sv
module sdram_bank_guard
  import sbg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RC      = 6,
  parameter int unsigned T_MRD     = 2,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS),
  localparam int unsigned MAX_LEN  = max_int(max_int(T_RCD, T_RP + 8), max_int(T_RC, T_MRD)),
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cke_i,
  input  logic [3:0]             cmd_i,
  input  logic [BA_W-1:0]        bank_i,
  input  logic [1:0]             burst_len_i,
  output logic [3*NUM_BANKS-1:0] bank_state_o,
  output logic                   all_idle_o,
  output logic                   illegal_o,
  output logic [2:0]             reason_o
);

  // Named internal events, also observed by the bound checker.
  logic                      track;
  logic                      glob_busy;
  logic [BA_W-1:0]           last_bank;
  logic                      last_valid;
  logic                      burst_start;
  glob_op_e                  glob_op;
  reason_e                   reason_d;
  bank_act_e [NUM_BANKS-1:0] bank_act;
  bank_st_e  [NUM_BANKS-1:0] bank_st;
  logic [CNT_W-1:0]          burst_len;
  logic                      illegal_q;
  reason_e                   reason_q;

  assign burst_len = CNT_W'(burst_cycles(burst_len_i));

  sbg_global #(
    .T_RP  (T_RP),
    .T_RC  (T_RC),
    .T_MRD (T_MRD),
    .CNT_W (CNT_W),
    .BA_W  (BA_W)
  ) i_global (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cke_i         (cke_i),
    .op_i          (glob_op),
    .burst_start_i (burst_start),
    .burst_bank_i  (bank_i),
    .track_o       (track),
    .busy_o        (glob_busy),
    .last_bank_o   (last_bank),
    .last_valid_o  (last_valid)
  );

  sbg_decode #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) i_decode (
    .cmd_i         (cmd_i),
    .bank_i        (bank_i),
    .states_i      (bank_st),
    .glob_busy_i   (glob_busy),
    .last_bank_i   (last_bank),
    .last_valid_i  (last_valid),
    .act_o         (bank_act),
    .op_o          (glob_op),
    .burst_start_o (burst_start),
    .reason_o      (reason_d)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sbg_bank #(
      .T_RCD (T_RCD),
      .T_RP  (T_RP),
      .CNT_W (CNT_W)
    ) i_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .track_i (track),
      .act_i   (bank_act[b]),
      .burst_i (burst_len),
      .state_o (bank_st[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      illegal_q <= 1'b0;
      reason_q  <= RSN_NONE;
    end else if (track) begin
      illegal_q <= (reason_d != RSN_NONE);
      reason_q  <= reason_d;
    end else begin
      illegal_q <= 1'b0;
      reason_q  <= RSN_NONE;
    end
  end

  always_comb begin
    all_idle_o = !glob_busy;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_st[b] != BS_IDLE) all_idle_o = 1'b0;
    end
  end

  assign bank_state_o = bank_st;
  assign illegal_o    = illegal_q;
  assign reason_o     = reason_q;

endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   track_i,
  input logic [3:0]             cmd_i,
  input logic                   glob_busy_i,
  input logic [3*NUM_BANKS-1:0] bank_state_i,
  input logic                   illegal_i,
  input logic [2:0]             reason_i,
  input logic                   all_idle_i
);

  AST_FLAG_HAS_REASON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_i == (reason_i != 3'd0)); // R14

  AST_HOLD_WITHOUT_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !track_i |=> ($stable(bank_state_i) && !illegal_i)); // R13

  AST_GLOBAL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track_i && glob_busy_i && cmd_i > 4'd1 && cmd_i <= 4'd11)
      |=> (illegal_i && reason_i == 3'd4)); // R9

  AST_REFRESH_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track_i && !glob_busy_i && !all_idle_i && (cmd_i == 4'd9 || cmd_i == 4'd10))
      |=> (illegal_i && reason_i == 3'd3)); // R8

  AST_UNKNOWN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (track_i && cmd_i > 4'd11) |=> (illegal_i && reason_i == 3'd5)); // R14

  AST_NOP_ALWAYS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i <= 4'd1) |=> !illegal_i); // R14

endmodule

bind sdram_bank_guard sbg_checker #(
  .NUM_BANKS (NUM_BANKS)
) i_sbg_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .track_i      (track),
  .cmd_i        (cmd_i),
  .glob_busy_i  (glob_busy),
  .bank_state_i (bank_state_o),
  .illegal_i    (illegal_o),
  .reason_i     (reason_o),
  .all_idle_i   (all_idle_o)
);

// File: tb/test_sdram_bank_guard.sv
`timescale 1ns/1ps
module test_sdram_bank_guard;

  localparam int unsigned TRCD = 2;
  localparam int unsigned TRP  = 2;
  localparam int unsigned TRC  = 3;
  localparam int unsigned TMRD = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke;
  logic [3:0]  cmd;
  logic [1:0]  bank;
  logic [1:0]  blen;
  logic [11:0] bank_state;
  logic        all_idle;
  logic        illegal;
  logic [2:0]  reason;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sdram_bank_guard #(
    .NUM_BANKS (4),
    .T_RCD     (TRCD),
    .T_RP      (TRP),
    .T_RC      (TRC),
    .T_MRD     (TMRD)
  ) i_sdram_bank_guard (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cke_i        (cke),
    .cmd_i        (cmd),
    .bank_i       (bank),
    .burst_len_i  (blen),
    .bank_state_o (bank_state),
    .all_idle_o   (all_idle),
    .illegal_o    (illegal),
    .reason_o     (reason)
  );

  // Expected bank states: one hex digit per bank, bank 3 leftmost.
  typedef struct packed {
    logic [3:0]  cmd;
    logic [1:0]  bank;
    logic [1:0]  blen;
    logic [15:0] st;
    logic        idle;
    logic        ill;
    logic [2:0]  rsn;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{4'd0,  2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0, 4'd1 },  // R1 NOP
    '{4'd2,  2'd0, 2'd0, 16'h0001, 1'b0, 1'b0, 3'd0, 4'd2 },  // R2 open bank 0
    '{4'd3,  2'd0, 2'd0, 16'h0002, 1'b0, 1'b1, 3'd1, 4'd6 },  // R6 read too early
    '{4'd3,  2'd0, 2'd1, 16'h0003, 1'b0, 1'b0, 3'd0, 4'd4 },  // R4 read, 2 cycles
    '{4'd0,  2'd0, 2'd0, 16'h0002, 1'b0, 1'b0, 3'd0, 4'd4 },  // R4 burst over
    '{4'd5,  2'd0, 2'd2, 16'h0004, 1'b0, 1'b0, 3'd0, 4'd4 },  // R4 write, 4 cycles
    '{4'd11, 2'd2, 2'd0, 16'h0002, 1'b0, 1'b0, 3'd0, 4'd11},  // R11 stop via bank 2
    '{4'd3,  2'd1, 2'd0, 16'h0002, 1'b0, 1'b1, 3'd2, 4'd7 },  // R7 read idle bank
    '{4'd9,  2'd0, 2'd0, 16'h0002, 1'b0, 1'b1, 3'd3, 4'd8 },  // R8 refresh not idle
    '{4'd4,  2'd0, 2'd1, 16'h0006, 1'b0, 1'b0, 3'd0, 4'd5 },  // R5 read auto close
    '{4'd2,  2'd0, 2'd0, 16'h0006, 1'b0, 1'b1, 3'd1, 4'd6 },  // R6 open while closing
    '{4'd2,  2'd1, 2'd0, 16'h0016, 1'b0, 1'b0, 3'd0, 4'd6 },  // R6 other bank free
    '{4'd0,  2'd0, 2'd0, 16'h0020, 1'b0, 1'b0, 3'd0, 4'd5 },  // R5 bank 0 idle
    '{4'd7,  2'd1, 2'd0, 16'h0050, 1'b0, 1'b0, 3'd0, 4'd3 },  // R3 close bank 1
    '{4'd7,  2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0, 4'd3 },  // R3 close idle bank
    '{4'd9,  2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 4'd8 },  // R8 refresh
    '{4'd2,  2'd2, 2'd0, 16'h0000, 1'b0, 1'b1, 3'd4, 4'd9 },  // R9 blocked
    '{4'd1,  2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0, 4'd9 },  // R9 inhibit legal
    '{4'd10, 2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 4'd8 },  // R8 mode load
    '{4'd0,  2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0, 4'd9 },  // R9 free again
    '{4'd13, 2'd0, 2'd0, 16'h0000, 1'b1, 1'b1, 3'd5, 4'd14},  // R14 unknown
    '{4'd2,  2'd3, 2'd0, 16'h1000, 1'b0, 1'b0, 3'd0, 4'd2 },  // R2 open bank 3
    '{4'd0,  2'd0, 2'd0, 16'h2000, 1'b0, 1'b0, 3'd0, 4'd2 },  // R2 open
    '{4'd6,  2'd3, 2'd0, 16'h7000, 1'b0, 1'b0, 3'd0, 4'd5 },  // R5 write auto close
    '{4'd8,  2'd0, 2'd0, 16'h7000, 1'b0, 1'b1, 3'd1, 4'd10},  // R10 close all refused
    '{4'd0,  2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0, 4'd5 },  // R5 idle after 1+TRP
    '{4'd2,  2'd2, 2'd0, 16'h0100, 1'b0, 1'b0, 3'd0, 4'd2 },  // R2 open bank 2
    '{4'd0,  2'd0, 2'd0, 16'h0200, 1'b0, 1'b0, 3'd0, 4'd2 },  // R2 open
    '{4'd3,  2'd2, 2'd3, 16'h0300, 1'b0, 1'b0, 3'd0, 4'd4 },  // R4 read, 8 cycles
    '{4'd3,  2'd2, 2'd0, 16'h0200, 1'b0, 1'b0, 3'd0, 4'd12},  // R12 restart, 1 cycle
    '{4'd8,  2'd0, 2'd0, 16'h0000, 1'b0, 1'b0, 3'd0, 4'd10},  // R10 close all
    '{4'd0,  2'd0, 2'd0, 16'h0000, 1'b1, 1'b0, 3'd0, 4'd10}   // R10 after TRP
  };

  task automatic check(input string req, input logic [15:0] st, input logic idle,
                       input logic ill, input logic [2:0] rsn);
    logic ok;
    ok = (all_idle === idle) && (illegal === ill) && (reason === rsn);
    for (int b = 0; b < 4; b++) begin
      if (bank_state[3*b +: 3] !== st[4*b +: 3]) ok = 1'b0;
    end
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got states=%h idle=%b ill=%b rsn=%0d, want states(hex/bank)=%h idle=%b ill=%b rsn=%0d",
               req, bank_state, all_idle, illegal, reason, st, idle, ill, rsn);
    end
  endtask

  // Drive just after a falling edge; outputs are read at the next falling edge.
  task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic [1:0] l);
    cmd  = c;
    bank = b;
    blen = l;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got no end, want end");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cke   = 1'b1;
    cmd   = 4'd0;
    bank  = 2'd0;
    blen  = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset", 16'h0000, 1'b1, 1'b0, 3'd0);
    rst_n = 1'b1;
    issue(4'd0, 2'd0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].cmd, VEC[i].bank, VEC[i].blen);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].st, VEC[i].idle,
            VEC[i].ill, VEC[i].rsn);
    end

    // R13: clock enable low freezes the opening phase and hides illegal commands.
    issue(4'd2, 2'd0, 2'd0);
    check("R13 open before cke drop", 16'h0001, 1'b0, 1'b0, 3'd0);
    cke = 1'b0;
    issue(4'd9, 2'd0, 2'd0);
    check("R13 cke low", 16'h0001, 1'b0, 1'b0, 3'd0);
    cke = 1'b1;
    issue(4'd9, 2'd0, 2'd0);
    check("R13 cke low last cycle", 16'h0001, 1'b0, 1'b0, 3'd0);
    issue(4'd0, 2'd0, 2'd0);
    check("R13 resumed", 16'h0002, 1'b0, 1'b0, 3'd0);

    // R4: an eight-cycle read stays in Reading for exactly eight cycles.
    issue(4'd3, 2'd0, 2'd3);
    check("R4 long read start", 16'h0003, 1'b0, 1'b0, 3'd0);
    repeat (6) issue(4'd0, 2'd0, 2'd0);
    check("R4 long read cycle 7", 16'h0003, 1'b0, 1'b0, 3'd0);
    issue(4'd0, 2'd0, 2'd0);
    check("R4 long read end", 16'h0002, 1'b0, 1'b0, 3'd0);

    // R14: an illegal refresh changes nothing and the flag lasts one cycle.
    issue(4'd9, 2'd0, 2'd0);
    check("R14 flagged", 16'h0002, 1'b0, 1'b1, 3'd3);
    issue(4'd0, 2'd0, 2'd0);
    check("R14 pulse ends", 16'h0002, 1'b0, 1'b0, 3'd0);

    // R1: reset in the middle of traffic.
    issue(4'd2, 2'd1, 2'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset with open banks", 16'h0000, 1'b1, 1'b0, 3'd0);
    rst_n = 1'b1;
    issue(4'd0, 2'd0, 2'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule